// File: doc/BRIEF.md
# Lead-Lag Carrier Loop Filter

This block is the second-order loop filter of a carrier recovery loop. Each valid sample of a signed phase-error word feeds two paths. The proportional path scales the error by a power of two. The integrating path adds a separately scaled copy of the error to a wide accumulator. The accumulator saturates instead of wrapping, so a loop that is pulled far off lock does not flip the sign of its frequency estimate.

The filter drives two destinations. One is a 32-bit frequency control word for a numerically controlled oscillator. The other is a full-width monitor word that goes to a serial read-out path. Each destination has its own routing bit. The oscillator word carries either the lead-plus-lag sum or the proportional term alone, and only its 32 most significant bits are used. The monitor word carries either the accumulator alone or the lead-plus-lag sum. A synchronous clear empties the accumulator, for example when acquisition restarts, and leaves every other register unchanged.

Top module: `lead_lag_loop_filter`

## Requirements
- R1: After reset, nco_word, mon_word and out_vld are all 0 and the accumulator holds 0.
- R2: The proportional term is err_in (two's complement, sign-extended to 40 bits) multiplied by 2^lead_sh, with lead_sh from 0 to 15.
- R3: On each cycle with err_vld high and lag_clr low, the accumulator adds err_in sign-extended and multiplied by 2^lag_sh (lag_sh from 0 to 15). In any cycle with err_vld low and lag_clr low, it keeps its value.
- R4: The 40-bit accumulator saturates: any result above 2^39-1 becomes 2^39-1, and any result below -2^39 becomes -2^39.
- R5: When lag_clr is high, the accumulator is 0 on the next cycle. If err_vld is high in the same cycle, that sample adds nothing to the accumulator, and the outputs it produces use a lag value of 0. A clear with err_vld low leaves nco_word and mon_word unchanged.
- R6: The sum is the proportional term plus the updated accumulator, formed exactly as a 41-bit signed value.
- R7: With mon_sum_sel = 0, mon_word is the updated accumulator sign-extended to 41 bits. With mon_sum_sel = 1, mon_word is the 41-bit sum.
- R8: With nco_lead_only = 0, nco_word is bits 40 down to 9 of the 41-bit sum. With nco_lead_only = 1, it is bits 40 down to 9 of the proportional term sign-extended to 41 bits.
- R9: The outputs are registered. They take new values at the clock edge that samples err_vld high, and they hold their values otherwise. out_vld is high for exactly the cycle after each valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_in | input | 16 | Signed phase error sample |
| err_vld | input | 1 | err_in is valid this cycle |
| lead_sh | input | 4 | Proportional gain shift |
| lag_sh | input | 4 | Integrator gain shift |
| nco_lead_only | input | 1 | Oscillator word source: 0 sum, 1 proportional term |
| mon_sum_sel | input | 1 | Monitor word source: 0 accumulator, 1 sum |
| lag_clr | input | 1 | Synchronous accumulator clear |
| nco_word | output | 32 | Oscillator frequency control word |
| mon_word | output | 41 | Monitor word |
| out_vld | output | 1 | Outputs were updated on the last edge |

## Verification
The saturation limits are the hardest state to reach from the ports. The accumulator is 40 bits wide, and one sample adds at most about 2^30. The stimulus therefore drives the largest positive error at the largest integrator shift in an unbroken run of several hundred valid cycles until the positive limit is reached and held. It then drives the most negative error for an even longer run to cross the whole range to the negative limit. The monitor is routed to the accumulator during both runs, so each step and the pinned value appear at the port. A clear that coincides with a valid sample is also driven on purpose, to check that the clear takes priority.

// File: rtl/lcf_pkg.sv
// Shared definitions for the lead-lag loop filter.
// Assumes nothing beyond the standard two's-complement conventions.
package lcf_pkg;
    // Source of the oscillator control word.
    typedef enum logic {
        NCO_FROM_SUM  = 1'b0,
        NCO_FROM_LEAD = 1'b1
    } nco_src_e;

    // Source of the monitor word.
    typedef enum logic {
        MON_FROM_LAG = 1'b0,
        MON_FROM_SUM = 1'b1
    } mon_src_e;
endpackage

// File: rtl/lcf_shift_gain.sv
// Power-of-two gain stage: sign-extends a signed error to OUT_W bits and
// shifts it left by a run-time amount. Purely combinational.
// Assumes IN_W + 2**SH_W - 1 <= OUT_W, so no shift can overflow.
module lcf_shift_gain #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 40,
    parameter int SH_W  = 4
) (
    input  logic [IN_W-1:0]  din,
    input  logic [SH_W-1:0]  sh,
    output logic [OUT_W-1:0] dout
);
    localparam int EXT_W = OUT_W - IN_W;

    logic [OUT_W-1:0] ext;

    // Sign-extend, then shift by the programmed gain.
    always_comb begin
        ext  = {{EXT_W{din[IN_W-1]}}, din};
        dout = ext << sh;
    end
endmodule

// File: rtl/lcf_lag_accum.sv
// Saturating integrator. It adds a step on each valid sample and clamps at
// the signed limits. A clear has priority over a sample. acc_nxt shows the
// value the register takes at the coming edge.
// Assumes step is already scaled and of the same width as the accumulator.
module lcf_lag_accum #(
    parameter int ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic             clr,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] acc_nxt,
    output logic [ACC_W-1:0] acc_q
);
    localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W:0] raw;

    // Next accumulator value: clear, saturating add, or hold.
    always_comb begin
        raw = {acc_q[ACC_W-1], acc_q} + {step[ACC_W-1], step};
        if (clr)
            acc_nxt = '0;
        else if (!add_en)
            acc_nxt = acc_q;
        else if (raw[ACC_W] != raw[ACC_W-1])
            acc_nxt = raw[ACC_W] ? NEG_LIM : POS_LIM;
        else
            acc_nxt = raw[ACC_W-1:0];
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= acc_nxt;
    end
endmodule

// File: rtl/lcf_out_route.sv
// Forms the exact lead-plus-lag sum and registers the two routed outputs.
// The outputs load only on a valid sample, and out_vld marks the cycle after.
// Assumes NCO_W <= ACC_W + 1.
module lcf_out_route #(
    parameter int ACC_W = 40,
    parameter int NCO_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] lead,
    input  logic [ACC_W-1:0] lag,
    input  lcf_pkg::nco_src_e nco_src,
    input  lcf_pkg::mon_src_e mon_src,
    output logic [NCO_W-1:0] nco_q,
    output logic [ACC_W:0]   mon_q,
    output logic             vld_q
);
    import lcf_pkg::*;

    localparam int SUM_W = ACC_W + 1;

    logic [SUM_W-1:0] lead_x;
    logic [SUM_W-1:0] lag_x;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] nco_full;
    logic [SUM_W-1:0] mon_full;

    // Exact sum and per-destination source selection.
    always_comb begin
        lead_x   = {lead[ACC_W-1], lead};
        lag_x    = {lag[ACC_W-1], lag};
        sum      = lead_x + lag_x;
        nco_full = (nco_src == NCO_FROM_LEAD) ? lead_x : sum;
        mon_full = (mon_src == MON_FROM_SUM) ? sum : lag_x;
    end

    // Output registers, loaded once per valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nco_q <= '0;
            mon_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= load;
            if (load) begin
                nco_q <= nco_full[SUM_W-1 -: NCO_W];
                mon_q <= mon_full;
            end
        end
    end
endmodule

// File: rtl/lead_lag_loop_filter.sv
// Second-order carrier loop filter. It has a shifted proportional path and a
// saturating integrator, and each of its two outputs has its own routing.
// Assumes ERR_W + 2**SH_W - 1 <= ACC_W and NCO_W <= ACC_W + 1.
module lead_lag_loop_filter #(
    parameter int ERR_W = 16,
    parameter int ACC_W = 40,
    parameter int SH_W  = 4,
    parameter int NCO_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_in,
    input  logic             err_vld,
    input  logic [SH_W-1:0]  lead_sh,
    input  logic [SH_W-1:0]  lag_sh,
    input  logic             nco_lead_only,
    input  logic             mon_sum_sel,
    input  logic             lag_clr,
    output logic [NCO_W-1:0] nco_word,
    output logic [ACC_W:0]   mon_word,
    output logic             out_vld
);
    import lcf_pkg::*;

    logic [ACC_W-1:0] lead_term;
    logic [ACC_W-1:0] lag_step;
    logic [ACC_W-1:0] lag_nxt;
    logic [ACC_W-1:0] lag_acc;
    nco_src_e         nco_src;
    mon_src_e         mon_src;

    // Map the routing bits onto the typed selects.
    always_comb begin
        nco_src = nco_lead_only ? NCO_FROM_LEAD : NCO_FROM_SUM;
        mon_src = mon_sum_sel ? MON_FROM_SUM : MON_FROM_LAG;
    end

    lcf_shift_gain #(.IN_W(ERR_W), .OUT_W(ACC_W), .SH_W(SH_W)) u_lead_gain (
        .din  (err_in),
        .sh   (lead_sh),
        .dout (lead_term)
    );

    lcf_shift_gain #(.IN_W(ERR_W), .OUT_W(ACC_W), .SH_W(SH_W)) u_lag_gain (
        .din  (err_in),
        .sh   (lag_sh),
        .dout (lag_step)
    );

    lcf_lag_accum #(.ACC_W(ACC_W)) u_lag (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (err_vld),
        .clr     (lag_clr),
        .step    (lag_step),
        .acc_nxt (lag_nxt),
        .acc_q   (lag_acc)
    );

    lcf_out_route #(.ACC_W(ACC_W), .NCO_W(NCO_W)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (err_vld),
        .lead    (lead_term),
        .lag     (lag_nxt),
        .nco_src (nco_src),
        .mon_src (mon_src),
        .nco_q   (nco_word),
        .mon_q   (mon_word),
        .vld_q   (out_vld)
    );
endmodule

// File: rtl/lcf_checker.sv
// Property checker for the loop filter. It is bound to the top module and
// watches the ports and the integrator register.
module lcf_checker #(
    parameter int ACC_W = 40,
    parameter int NCO_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_vld,
    input logic             err_neg,
    input logic             lag_clr,
    input logic             mon_sum_sel,
    input logic [ACC_W-1:0] lag_q,
    input logic [NCO_W-1:0] nco_word,
    input logic [ACC_W:0]   mon_word,
    input logic             out_vld
);
    localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        lag_clr |=> lag_q == '0);  // R5
    AST_LAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_vld && !lag_clr) |=> $stable(lag_q));  // R3
    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (lag_q == POS_LIM && err_vld && !err_neg && !lag_clr) |=> lag_q == POS_LIM);  // R4
    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (lag_q == NEG_LIM && err_vld && err_neg && !lag_clr) |=> lag_q == NEG_LIM);  // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !err_vld |=> ($stable(nco_word) && $stable(mon_word)));  // R9
    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld |=> out_vld);  // R9
    AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !err_vld |=> !out_vld);  // R9
    AST_MON_IS_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && !mon_sum_sel) |=> mon_word == {lag_q[ACC_W-1], lag_q});  // R7
endmodule

bind lead_lag_loop_filter lcf_checker #(.ACC_W(ACC_W), .NCO_W(NCO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_vld     (err_vld),
    .err_neg     (err_in[ERR_W-1]),
    .lag_clr     (lag_clr),
    .mon_sum_sel (mon_sum_sel),
    .lag_q       (lag_acc),
    .nco_word    (nco_word),
    .mon_word    (mon_word),
    .out_vld     (out_vld)
);

// File: tb/lead_lag_loop_filter_test.sv
// Scoreboard bench: the driver computes expected outputs from the
// requirements and queues them; a monitor compares on each out_vld.
module lead_lag_loop_filter_test;
    localparam longint POS_LIM = (64'sd1 <<< 39) - 1;
    localparam longint NEG_LIM = -(64'sd1 <<< 39);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] err_in = '0;
    logic        err_vld = 1'b0;
    logic [3:0]  lead_sh = '0;
    logic [3:0]  lag_sh = '0;
    logic        nco_lead_only = 1'b0;
    logic        mon_sum_sel = 1'b0;
    logic        lag_clr = 1'b0;
    logic [31:0] nco_word;
    logic [40:0] mon_word;
    logic        out_vld;

    int n_checks = 0;
    int n_fail = 0;
    longint acc_m = 0;
    logic [31:0] exp_nco_q[$];
    logic [40:0] exp_mon_q[$];
    string       exp_tag_q[$];

    always #2.5 clk = ~clk;

    lead_lag_loop_filter uut (
        .clk(clk), .rst_n(rst_n), .err_in(err_in), .err_vld(err_vld),
        .lead_sh(lead_sh), .lag_sh(lag_sh), .nco_lead_only(nco_lead_only),
        .mon_sum_sel(mon_sum_sel), .lag_clr(lag_clr),
        .nco_word(nco_word), .mon_word(mon_word), .out_vld(out_vld)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one valid sample and queue the outputs the requirements predict.
    task automatic send(input string tag, input int err, input int lsh, input int gsh,
                        input bit nsel, input bit msel, input bit clr);
        longint lead, nxt;
        logic [63:0] sum, ncov;
        lead = longint'(err) <<< lsh;
        if (clr) nxt = 0;
        else begin
            nxt = acc_m + (longint'(err) <<< gsh);
            if (nxt > POS_LIM) nxt = POS_LIM;
            if (nxt < NEG_LIM) nxt = NEG_LIM;
        end
        acc_m = nxt;
        sum = 64'(lead + nxt);
        ncov = nsel ? 64'(lead) : sum;
        exp_nco_q.push_back(ncov[40:9]);
        exp_mon_q.push_back(msel ? sum[40:0] : 41'(nxt));
        exp_tag_q.push_back(tag);
        err_in = 16'(err); lead_sh = 4'(lsh); lag_sh = 4'(gsh);
        nco_lead_only = nsel; mon_sum_sel = msel; lag_clr = clr; err_vld = 1'b1;
        @(negedge clk);
        err_vld = 1'b0; lag_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        err_vld = 1'b0; lag_clr = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each produced result with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (exp_tag_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R9 actual=out_vld expected=no output");
            end else begin
                string t;
                t = exp_tag_q.pop_front();
                check({t, " nco"}, 64'(nco_word), 64'(exp_nco_q.pop_front()));
                check({t, " mon"}, 64'(mon_word), 64'(exp_mon_q.pop_front()));
            end
        end
    end

    initial begin
        #(100000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] hold_nco;
        logic [40:0] hold_mon;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 nco", 64'(nco_word), 64'd0);
        check("R1 mon", 64'(mon_word), 64'd0);
        check("R1 vld", 64'(out_vld), 64'd0);
        send("R1 lag", 0, 0, 0, 1'b0, 1'b0, 1'b0);
        idle(1);
        // R2: proportional term alone on the oscillator word.
        send("R2 pos", 16'sd12345, 15, 0, 1'b1, 1'b0, 1'b0);
        send("R2 neg", -1000, 9, 0, 1'b1, 1'b0, 1'b0);
        send("R2 min", -32768, 15, 0, 1'b1, 1'b0, 1'b0);
        send("R2 zero sh", 700, 0, 0, 1'b1, 1'b0, 1'b0);
        idle(2);
        // R3: integration at several shifts, back to back and spaced.
        send("R3 a", 3000, 0, 4, 1'b0, 1'b0, 1'b0);
        send("R3 b", -500, 0, 10, 1'b0, 1'b0, 1'b0);
        idle(3);
        send("R3 c", 77, 0, 15, 1'b0, 1'b0, 1'b0);
        // R9: outputs hold while no sample arrives.
        hold_nco = nco_word; hold_mon = mon_word;
        idle(4);
        check("R9 hold nco", 64'(nco_word), 64'(hold_nco));
        check("R9 hold mon", 64'(mon_word), 64'(hold_mon));
        check("R9 vld low", 64'(out_vld), 64'd0);
        // R6, R7, R8: sum routing combinations.
        send("R6 sum both", 20000, 12, 3, 1'b0, 1'b1, 1'b0);
        send("R7 mon sum nco lead", -9000, 14, 2, 1'b1, 1'b1, 1'b0);
        send("R8 nco sum mon lag", -32768, 15, 15, 1'b0, 1'b0, 1'b0);
        idle(2);
        // R5: clear alone leaves outputs, then empties the integrator.
        hold_nco = nco_word; hold_mon = mon_word;
        lag_clr = 1'b1;
        @(negedge clk);
        lag_clr = 1'b0;
        acc_m = 0;
        @(negedge clk);
        check("R5 clr nco", 64'(nco_word), 64'(hold_nco));
        check("R5 clr mon", 64'(mon_word), 64'(hold_mon));
        send("R5 after clr", 0, 0, 0, 1'b0, 1'b0, 1'b0);
        send("R5 build", 4000, 0, 8, 1'b0, 1'b0, 1'b0);
        send("R5 clr with vld", 4000, 3, 8, 1'b0, 1'b1, 1'b1);
        send("R5 after", 1, 0, 0, 1'b0, 1'b0, 1'b0);
        idle(2);
        // R4: drive to the positive limit, then across to the negative one.
        for (int i = 0; i < 520; i++) send("R4 up", 32767, 0, 15, 1'b0, 1'b0, 1'b0);
        send("R4 hi sum", 32767, 15, 15, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 1040; i++) send("R4 down", -32768, 0, 15, 1'b0, 1'b0, 1'b0);
        send("R4 lo sum", -32768, 15, 15, 1'b1, 1'b1, 1'b0);
        send("R4 off limit", 5, 0, 0, 1'b0, 1'b0, 1'b0);
        idle(3);
        check("R9 queue drained", 64'(exp_tag_q.size()), 64'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule